// File: doc/BRIEF.md
# Sample-Stream Recorder Controller

This block sequences a single-board audio recorder whose sample store is a sequential-access line memory: the memory keeps its own write and read pointers, so the controller never drives an address. Instead it opens and closes the memory's write and read clocks through enable outputs, strobes the memory's write enable, and clears either pointer when a new pass begins. A built-in sample counter ends each pass once the full depth of the memory has been written or read.

Two active-low push buttons choose the operation. Pressing record clears the write pointer for one cycle and then streams one converter sample into the memory per clock. Pressing play clears the read pointer for one cycle and then streams the stored samples out to the output converter. Each pass stops when the counter reaches the memory depth or when an external stop request is raised, and the controller then waits for the next press. All outputs are clock enables and levels, so the whole system stays on one clock.

Top module: `rec_ctrl_top`

## Requirements
- R1: While `rst_ni` is low, and for as long as the internal reset takes to release after it rises, the outputs show the idle pattern; asserting `rst_ni` low forces idle at once, without waiting for a clock edge.
- R2: In idle every output is 0 except `cnt_rst_o`, which is 1; the idle state ignores `stop_req_i` and stays idle while both buttons read 1.
- R3: A record button low (`rec_btn_ni`=0) sampled in idle gives, after that edge, exactly one cycle of the write-pointer clear pattern (`mem_wptr_rst_o`=1, `mem_wclk_en_o`=1, `cnt_rst_o`=1, all else 0), followed by record.
- R4: A play button low with the record button high, sampled in idle, gives exactly one cycle of the read-pointer clear pattern (`mem_rptr_rst_o`=1, `mem_rclk_en_o`=1, `cnt_rst_o`=1, all else 0), followed by play.
- R5: When both buttons are low in idle, record wins: the write-pointer clear pattern follows.
- R6: In record, `mem_wr_en_o`, `mem_wclk_en_o` and `cnt_clk_en_o` are 1 and all other outputs are 0.
- R7: In play, `mem_rclk_en_o` and `cnt_clk_en_o` are 1 and all other outputs are 0.
- R8: `stop_req_i` high during a record or play cycle returns the controller to idle at the next edge.
- R9: Without a stop request, a record or play pass lasts exactly DEPTH cycles; the counter is cleared in idle, so a pass that was stopped early is followed by a full DEPTH-cycle pass.
- R10: `stop_req_i` is ignored in both pointer-clear states (the pass still begins), and the buttons are ignored while recording or playing.
- R11: `mem_wclk_en_o` and `mem_rclk_en_o` are never 1 together, and `mem_wr_en_o` is 1 only while `mem_wclk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rec_btn_ni | input | 1 | Record button, active low |
| play_btn_ni | input | 1 | Play button, active low |
| stop_req_i | input | 1 | External stop request, active high |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wclk_en_o | output | 1 | Enable for the memory write clock |
| mem_rclk_en_o | output | 1 | Enable for the memory read clock |
| mem_wptr_rst_o | output | 1 | Clear for the memory write pointer |
| mem_rptr_rst_o | output | 1 | Clear for the memory read pointer |
| cnt_clk_en_o | output | 1 | Sample counter clock enable |
| cnt_rst_o | output | 1 | Sample counter reset |

## Verification
Record and play passes are run to their natural end, which measures the pass length against DEPTH and shows the counter trip rather than a stray stop. Early stop requests in both passes, followed by a fresh full pass, separate a counter that is cleared in idle from one that keeps its old count. Both buttons pressed together distinguish record priority from play priority, and a stop request held across idle and the pointer-clear cycle shows that those states ignore it. A play button held through a whole record pass shows that buttons are ignored mid-pass yet act again once idle, and an asynchronous reset in mid-pass shows that idle is forced without a clock edge.

// File: rtl/rec_ctrl_pkg.sv
package rec_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WPTR_CLR = 3'd1,
    ST_RECORD   = 3'd2,
    ST_RPTR_CLR = 3'd3,
    ST_PLAY     = 3'd4
  } rec_state_e;

  typedef struct packed {
    logic wr_en;
    logic wclk_en;
    logic rclk_en;
    logic wptr_rst;
    logic rptr_rst;
    logic cnt_clk_en;
    logic cnt_rst;
  } rec_ctl_t;

endpackage

// File: rtl/rec_ctrl_rst_sync.sv
module rec_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/rec_ctrl_smp_cnt.sv
module rec_ctrl_smp_cnt #(
  parameter int DEPTH = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic term_o
);

  localparam int CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // the cycle that moves the DEPTH-th sample is the last one of the pass
  assign term_o = en_i & ~clr_i & (cnt_q == LAST);

endmodule

// File: rtl/rec_ctrl_fsm.sv
module rec_ctrl_fsm
  import rec_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rec_req_i,
  input  logic     play_req_i,
  input  logic     stop_i,
  output rec_ctl_t ctl_o
);

  rec_state_e state_q;
  rec_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (rec_req_i) begin
          state_d = ST_WPTR_CLR;
        end else if (play_req_i) begin
          state_d = ST_RPTR_CLR;
        end
      end
      ST_WPTR_CLR: state_d = ST_RECORD;
      ST_RECORD:   if (stop_i) state_d = ST_IDLE;
      ST_RPTR_CLR: state_d = ST_PLAY;
      ST_PLAY:     if (stop_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    ctl_o         = '0;
    ctl_o.cnt_rst = 1'b1;
    case (state_q)
      ST_WPTR_CLR: begin
        ctl_o.wptr_rst = 1'b1;
        ctl_o.wclk_en  = 1'b1;
      end
      ST_RECORD: begin
        ctl_o.wr_en      = 1'b1;
        ctl_o.wclk_en    = 1'b1;
        ctl_o.cnt_clk_en = 1'b1;
        ctl_o.cnt_rst    = 1'b0;
      end
      ST_RPTR_CLR: begin
        ctl_o.rptr_rst = 1'b1;
        ctl_o.rclk_en  = 1'b1;
      end
      ST_PLAY: begin
        ctl_o.rclk_en    = 1'b1;
        ctl_o.cnt_clk_en = 1'b1;
        ctl_o.cnt_rst    = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rec_ctrl_top.sv
module rec_ctrl_top
  import rec_ctrl_pkg::*;
#(
  parameter int DEPTH       = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_btn_ni,
  input  logic play_btn_ni,
  input  logic stop_req_i,
  output logic mem_wr_en_o,
  output logic mem_wclk_en_o,
  output logic mem_rclk_en_o,
  output logic mem_wptr_rst_o,
  output logic mem_rptr_rst_o,
  output logic cnt_clk_en_o,
  output logic cnt_rst_o
);

  logic     rst_int_n;
  logic     term;
  logic     stop;
  rec_ctl_t ctl;

  rec_ctrl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  rec_ctrl_smp_cnt #(.DEPTH(DEPTH)) u_smp_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .clr_i  (ctl.cnt_rst),
    .en_i   (ctl.cnt_clk_en),
    .term_o (term)
  );

  assign stop = term | stop_req_i;

  rec_ctrl_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .rec_req_i  (~rec_btn_ni),
    .play_req_i (~play_btn_ni),
    .stop_i     (stop),
    .ctl_o      (ctl)
  );

  assign mem_wr_en_o    = ctl.wr_en;
  assign mem_wclk_en_o  = ctl.wclk_en;
  assign mem_rclk_en_o  = ctl.rclk_en;
  assign mem_wptr_rst_o = ctl.wptr_rst;
  assign mem_rptr_rst_o = ctl.rptr_rst;
  assign cnt_clk_en_o   = ctl.cnt_clk_en;
  assign cnt_rst_o      = ctl.cnt_rst;

endmodule

// File: rtl/rec_ctrl_chk.sv
module rec_ctrl_chk #(
  parameter int DEPTH = 32768
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_req_i,
  input logic mem_wr_en_o,
  input logic mem_wclk_en_o,
  input logic mem_rclk_en_o,
  input logic mem_wptr_rst_o,
  input logic mem_rptr_rst_o,
  input logic cnt_clk_en_o,
  input logic cnt_rst_o
);

  localparam int RW = $clog2(DEPTH + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (cnt_clk_en_o) begin
      if (run_q != RW'(DEPTH)) run_q <= run_q + RW'(1);
    end else begin
      run_q <= '0;
    end
  end

  p_clk_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wclk_en_o && mem_rclk_en_o));

  p_wr_needs_wclk_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o |-> mem_wclk_en_o);

  p_cnt_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clk_en_o |-> cnt_rst_o);

  p_wptr_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wptr_rst_o |=> (!mem_wptr_rst_o && mem_wr_en_o));

  p_rptr_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rptr_rst_o |=> (!mem_rptr_rst_o && mem_rclk_en_o && cnt_clk_en_o));

  p_stop_record_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_en_o && stop_req_i) |=> !mem_wr_en_o);

  p_stop_play_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rclk_en_o && !mem_rptr_rst_o && stop_req_i) |=> !mem_rclk_en_o);

  p_pass_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clk_en_o |-> (run_q < RW'(DEPTH)));

endmodule

bind rec_ctrl_top rec_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stop_req_i     (stop_req_i),
  .mem_wr_en_o    (mem_wr_en_o),
  .mem_wclk_en_o  (mem_wclk_en_o),
  .mem_rclk_en_o  (mem_rclk_en_o),
  .mem_wptr_rst_o (mem_wptr_rst_o),
  .mem_rptr_rst_o (mem_rptr_rst_o),
  .cnt_clk_en_o   (cnt_clk_en_o),
  .cnt_rst_o      (cnt_rst_o)
);

// File: tb/rec_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module rec_ctrl_top_tb_top;

  localparam int DEPTH = 8;
  // pattern order: wr_en, wclk_en, rclk_en, wptr_rst, rptr_rst, cnt_clk_en, cnt_rst
  localparam logic [6:0] P_IDLE = 7'b000_00_01;
  localparam logic [6:0] P_WCLR = 7'b010_10_01;
  localparam logic [6:0] P_RCLR = 7'b001_01_01;
  localparam logic [6:0] P_REC  = 7'b110_00_10;
  localparam logic [6:0] P_PLAY = 7'b001_00_10;

  logic clk_i = 1'b0;
  logic rst_ni, rec_btn_ni, play_btn_ni, stop_req_i;
  logic mem_wr_en_o, mem_wclk_en_o, mem_rclk_en_o;
  logic mem_wptr_rst_o, mem_rptr_rst_o, cnt_clk_en_o, cnt_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  rec_ctrl_top #(.DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .rec_btn_ni, .play_btn_ni, .stop_req_i,
    .mem_wr_en_o, .mem_wclk_en_o, .mem_rclk_en_o,
    .mem_wptr_rst_o, .mem_rptr_rst_o, .cnt_clk_en_o, .cnt_rst_o
  );

  function automatic logic [6:0] pat();
    return {mem_wr_en_o, mem_wclk_en_o, mem_rclk_en_o,
            mem_wptr_rst_o, mem_rptr_rst_o, cnt_clk_en_o, cnt_rst_o};
  endfunction

  task automatic chk(input string tag, input logic [6:0] exp);
    checks++;
    if (pat() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, pat(), exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive buttons at a falling edge; returns one falling edge later
  task automatic press(input logic rec_n, input logic play_n);
    @(negedge clk_i);
    rec_btn_ni  = rec_n;
    play_btn_ni = play_n;
    @(negedge clk_i);
  endtask

  task automatic release_btns();
    rec_btn_ni  = 1'b1;
    play_btn_ni = 1'b1;
  endtask

  task automatic count_run(input logic [6:0] p, output int n);
    n = 0;
    @(negedge clk_i);
    while (pat() === p && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; release_btns(); stop_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 idle during reset", P_IDLE);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 idle after reset release", P_IDLE);
  endtask

  task automatic t_idle_hold();
    stop_req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R2 idle holds without buttons", P_IDLE);
    end
    stop_req_i = 1'b0;
  endtask

  task automatic t_record_full();
    int n;
    press(1'b0, 1'b1);
    chk("R3 write pointer clear", P_WCLR);
    release_btns();
    count_run(P_REC, n);
    chk_int("R6 R9 record pass length", n, DEPTH);
    chk("R9 idle after record pass", P_IDLE);
  endtask

  task automatic t_play_full();
    int n;
    press(1'b1, 1'b0);
    chk("R4 read pointer clear", P_RCLR);
    release_btns();
    count_run(P_PLAY, n);
    chk_int("R7 R11 R9 play pass length", n, DEPTH);
    chk("R9 idle after play pass", P_IDLE);
  endtask

  task automatic t_priority();
    int n;
    press(1'b0, 1'b0);
    chk("R5 record wins over play", P_WCLR);
    release_btns();
    count_run(P_REC, n);
    chk_int("R5 record pass after both pressed", n, DEPTH);
  endtask

  task automatic t_stop_record();
    int n;
    press(1'b0, 1'b1);
    release_btns();
    @(negedge clk_i);
    chk("R6 record pattern", P_REC);
    repeat (2) @(negedge clk_i);
    stop_req_i = 1'b1;
    @(negedge clk_i);
    chk("R8 stop ends record", P_IDLE);
    stop_req_i = 1'b0;
    press(1'b0, 1'b1);
    release_btns();
    count_run(P_REC, n);
    chk_int("R9 full record after early stop", n, DEPTH);
  endtask

  task automatic t_stop_play();
    int n;
    press(1'b1, 1'b0);
    release_btns();
    @(negedge clk_i);
    chk("R7 play pattern", P_PLAY);
    @(negedge clk_i);
    stop_req_i = 1'b1;
    @(negedge clk_i);
    chk("R8 stop ends play", P_IDLE);
    stop_req_i = 1'b0;
    press(1'b1, 1'b0);
    release_btns();
    count_run(P_PLAY, n);
    chk_int("R9 full play after early stop", n, DEPTH);
  endtask

  task automatic t_stop_ignored();
    stop_req_i = 1'b1;
    press(1'b0, 1'b1);
    chk("R10 stop ignored in idle, write clear", P_WCLR);
    release_btns();
    @(negedge clk_i);
    chk("R10 write clear moves to record under stop", P_REC);
    @(negedge clk_i);
    chk("R8 stop held ends record", P_IDLE);
    press(1'b1, 1'b0);
    chk("R10 read clear under stop", P_RCLR);
    release_btns();
    @(negedge clk_i);
    chk("R10 read clear moves to play under stop", P_PLAY);
    @(negedge clk_i);
    chk("R8 stop held ends play", P_IDLE);
    stop_req_i = 1'b0;
  endtask

  task automatic t_buttons_ignored();
    int n;
    press(1'b0, 1'b1);
    chk("R3 write clear before held play", P_WCLR);
    rec_btn_ni  = 1'b1;
    play_btn_ni = 1'b0;
    count_run(P_REC, n);
    chk_int("R10 held play ignored during record", n, DEPTH);
    @(negedge clk_i);
    chk("R4 held play acts once idle", P_RCLR);
    release_btns();
    count_run(P_PLAY, n);
    chk_int("R10 play pass after held button", n, DEPTH);
  endtask

  task automatic t_async_reset();
    press(1'b0, 1'b1);
    release_btns();
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 chk("R1 async reset forces idle", P_IDLE);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 idle after mid-pass reset", P_IDLE);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) cycles++;

  initial begin
    t_reset();
    t_idle_hold();
    t_record_full();
    t_play_full();
    t_priority();
    t_stop_record();
    t_stop_play();
    t_stop_ignored();
    t_buttons_ignored();
    t_async_reset();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule